// File: doc/BRIEF.md
# Read/Write Bus Turnaround Arbiter

This block chooses, cycle by cycle, whether a memory controller's single shared data bus carries a read or a write. Reads are served by default and are granted in the cycle they are offered. Writes do not go out on arrival. Each accepted write request adds one to a pending-write occupancy counter that stands for the write buffer, and each issued write removes one. When the occupancy climbs to a high mark, the block switches into a drain phase. In that phase only writes are issued, and pending reads wait. The phase ends when the occupancy falls to a low mark.

Each reversal of the bus direction costs a fixed number of dead cycles, and no command of either kind is granted during them. When no read is waiting and the buffer holds writes, writes are issued opportunistically outside the drain phase. A surrounding controller connects its read queue to the read handshake and its write path to the write handshake. It then takes the granted command, with its direction flag, to its command sequencer.

Top module: `rw_turn_arbiter`

## Requirements
- R1: After reset the occupancy is 0, no grant is given, write ready is high, and the bus faces reads. A read offered in the first cycle after reset is therefore granted in that same cycle.
- R2: Each cycle in which wrValid and wrReady are both high raises the occupancy by one at the next edge. Each write grant lowers it by one. The occupancy never exceeds DEPTH and never goes below zero.
- R3: wrReady is low exactly when the occupancy equals DEPTH. A write offered while wrReady is low is not counted.
- R4: Outside the drain phase, with the bus facing reads and no turnaround in progress, a valid read is granted in the same cycle. A read grant shows as grantValid=1, grantWrite=0, rdReady=1.
- R5: Outside the drain phase, with no read valid and a nonzero occupancy, writes are issued (grantValid=1, grantWrite=1). A turnaround is taken first if the bus faces reads.
- R6: The drain phase starts when the occupancy, after the edge, is at least HIGH_MARK. While it lasts, no read is granted, even when rdValid is high.
- R7: The drain phase ends when the occupancy, after the edge, is at most LOW_MARK. Reads are then granted again, subject to the turnaround.
- R8: A change of direction leaves at least TURN_CYCLES cycles with no grant between the last grant in the old direction and the first grant in the new one. When the new direction is wanted at once, the gap is exactly TURN_CYCLES.
- R9: At most one command is granted per cycle. rdReady equals grantValid with grantWrite low, and grantWrite is never high without grantValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | A read command is waiting |
| rdReady | output | 1 | The waiting read is granted this cycle |
| wrValid | input | 1 | A write request is offered to the buffer |
| wrReady | output | 1 | The buffer can take the offered write |
| wrOccupancy | output | $clog2(DEPTH+1) | Number of writes held in the buffer |
| grantValid | output | 1 | A command is granted on the bus this cycle |
| grantWrite | output | 1 | The granted command is a write (0 = read) |

## Verification
The assertions assume a well-behaved environment. rdValid and wrValid must be known after reset, and the parameters must satisfy LOW_MARK < HIGH_MARK <= DEPTH and TURN_CYCLES >= 1. Under those assumptions the occupancy, direction and drain-phase properties follow from the design alone. The bench drives both valids at the falling edge from a fixed-seed random source. Their probabilities change by segment, so that long read-heavy, write-heavy and idle stretches all occur. The bench parameters put HIGH_MARK plus TURN_CYCLES above DEPTH, so a drain that starts with the bus facing reads reaches a full buffer and exercises the back-pressure path.

// File: rtl/rw_arb_pkg.sv
package rw_arb_pkg;

  // Current orientation of the shared data bus.
  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } busDir_e;

  // Strobes from the control module to the counter datapath.
  typedef struct packed {
    logic takeWrite;   // a write request enters the buffer
    logic issueWrite;  // a buffered write is granted onto the bus
    logic startTurn;   // a bus direction change begins
  } arbStrobe_t;

endpackage

// File: rtl/rw_arb_datapath.sv
module rw_arb_datapath
  import rw_arb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int TURN_CYCLES = 3,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int TURN_W     = (TURN_CYCLES > 1) ? $clog2(TURN_CYCLES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobe_t       strobe,
  output logic [CNT_W-1:0] occupancy,
  output logic [CNT_W-1:0] occNext,
  output logic             bufFull,
  output logic             turnBusy
);

  localparam logic [CNT_W-1:0]  DEPTH_C     = CNT_W'(DEPTH);
  localparam logic [TURN_W-1:0] TURN_LOAD_C = TURN_W'(TURN_CYCLES - 1);

  logic [CNT_W-1:0]  occReg;
  logic [TURN_W-1:0] turnCnt;
  logic [CNT_W-1:0]  incAmt;
  logic [CNT_W-1:0]  decAmt;

  // Occupancy arithmetic: one in and one out may happen in the same cycle.
  always_comb begin
    incAmt  = CNT_W'(strobe.takeWrite);
    decAmt  = CNT_W'(strobe.issueWrite);
    occNext = occReg + incAmt - decAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occReg <= '0;
    end else begin
      occReg <= occNext;
    end
  end

  // Turnaround counter. It is loaded in the cycle the direction changes,
  // and that cycle is already the first dead cycle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      turnCnt <= '0;
    end else if (strobe.startTurn) begin
      turnCnt <= TURN_LOAD_C;
    end else if (turnCnt != '0) begin
      turnCnt <= turnCnt - TURN_W'(1);
    end
  end

  assign occupancy = occReg;
  assign bufFull   = (occReg == DEPTH_C);
  assign turnBusy  = (turnCnt != '0);

  // R2: the counter stays inside the buffer.
  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    occReg <= DEPTH_C);

  // R2: no write issues from an empty buffer.
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueWrite |-> (occReg != '0));

  // R3: a full buffer never takes another write.
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeWrite |-> !bufFull);

  // R2: the counter moves by exactly the two strobes.
  assert_occ_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeWrite && !strobe.issueWrite) |=> (occReg == $past(occReg) + CNT_W'(1)));

  // R8: a new turnaround never starts while one is still running.
  assert_turn_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startTurn |-> !turnBusy);

endmodule

// File: rtl/rw_arb_control.sv
module rw_arb_control
  import rw_arb_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdValid,
  input  logic             wrValid,
  input  logic [CNT_W-1:0] occupancy,
  input  logic [CNT_W-1:0] occNext,
  input  logic             bufFull,
  input  logic             turnBusy,
  output arbStrobe_t       strobe,
  output logic             rdReady,
  output logic             wrReady,
  output logic             grantValid,
  output logic             grantWrite
);

  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_MARK);

  busDir_e busDir;
  busDir_e wantDir;
  logic    wantValid;
  logic    canAct;
  logic    drainMode;
  logic    drainNext;
  logic    hasWrites;

  // Direction wanted this cycle. The drain phase forces writes. Otherwise
  // reads come first, and buffered writes fill the idle read slots.
  always_comb begin
    hasWrites = (occupancy != '0);
    wantValid = 1'b0;
    wantDir   = DIR_READ;
    if (drainMode) begin
      wantValid = hasWrites;
      wantDir   = DIR_WRITE;
    end else if (rdValid) begin
      wantValid = 1'b1;
      wantDir   = DIR_READ;
    end else if (hasWrites) begin
      wantValid = 1'b1;
      wantDir   = DIR_WRITE;
    end
  end

  // Grant, or begin a turnaround, only when the dead time has run out.
  always_comb begin
    canAct     = wantValid && !turnBusy;
    grantValid = canAct && (wantDir == busDir);
    grantWrite = grantValid && (busDir == DIR_WRITE);
    rdReady    = grantValid && (busDir == DIR_READ);
    wrReady    = !bufFull;

    strobe.takeWrite  = wrValid && !bufFull;
    strobe.issueWrite = grantWrite;
    strobe.startTurn  = canAct && (wantDir != busDir);
  end

  // Hysteresis between the two marks, evaluated on the next occupancy.
  always_comb begin
    if (drainMode) begin
      drainNext = (occNext > LOW_C);
    end else begin
      drainNext = (occNext >= HIGH_C);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busDir    <= DIR_READ;
      drainMode <= 1'b0;
    end else begin
      drainMode <= drainNext;
      if (strobe.startTurn) begin
        busDir <= wantDir;
      end
    end
  end

  // R6: reads are held while draining.
  assert_drain_holds_reads_R6: assert property (@(posedge clk) disable iff (!rstN)
    drainMode |-> !rdReady);

  // R6: draining begins only at or above the high mark.
  assert_drain_entry_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drainMode) |-> (occupancy >= HIGH_C));

  // R7: draining ends only at or below the low mark.
  assert_drain_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(drainMode) |-> (occupancy <= LOW_C));

  // R8: nothing is granted during dead cycles.
  assert_turn_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    turnBusy |-> !grantValid);

  // R4: a read grant always answers a valid read.
  assert_read_has_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> rdValid);

  // R9: one command per cycle, with a consistent direction flag.
  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdReady, grantWrite}) == {31'd0, grantValid});

endmodule

// File: rtl/rw_turn_arbiter.sv
module rw_turn_arbiter
  import rw_arb_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int HIGH_MARK   = 12,
  parameter int LOW_MARK    = 4,
  parameter int TURN_CYCLES = 3,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int GAP_W      = $clog2(TURN_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdValid,
  output logic             rdReady,
  input  logic             wrValid,
  output logic             wrReady,
  output logic [CNT_W-1:0] wrOccupancy,
  output logic             grantValid,
  output logic             grantWrite
);

  arbStrobe_t       strobe;
  logic [CNT_W-1:0] occupancy;
  logic [CNT_W-1:0] occNext;
  logic             bufFull;
  logic             turnBusy;

  rw_arb_control #(
    .DEPTH     (DEPTH),
    .HIGH_MARK (HIGH_MARK),
    .LOW_MARK  (LOW_MARK)
  ) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .rdValid    (rdValid),
    .wrValid    (wrValid),
    .occupancy  (occupancy),
    .occNext    (occNext),
    .bufFull    (bufFull),
    .turnBusy   (turnBusy),
    .strobe     (strobe),
    .rdReady    (rdReady),
    .wrReady    (wrReady),
    .grantValid (grantValid),
    .grantWrite (grantWrite)
  );

  rw_arb_datapath #(
    .DEPTH       (DEPTH),
    .TURN_CYCLES (TURN_CYCLES)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .occupancy (occupancy),
    .occNext   (occNext),
    .bufFull   (bufFull),
    .turnBusy  (turnBusy)
  );

  assign wrOccupancy = occupancy;

  // Gap tracker for the turnaround check. It counts idle cycles since the
  // last grant and saturates at TURN_CYCLES.
  localparam logic [GAP_W-1:0] GAP_MAX_C = GAP_W'(TURN_CYCLES);

  logic [GAP_W-1:0] idleSince;
  logic             lastWasWrite;
  logic             seenGrant;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleSince    <= '0;
      lastWasWrite <= 1'b0;
      seenGrant    <= 1'b0;
    end else if (grantValid) begin
      idleSince    <= '0;
      lastWasWrite <= grantWrite;
      seenGrant    <= 1'b1;
    end else if (idleSince != GAP_MAX_C) begin
      idleSince <= idleSince + GAP_W'(1);
    end
  end

  // R8: a grant in the opposite direction follows at least TURN_CYCLES idle cycles.
  assert_turn_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && seenGrant && (grantWrite != lastWasWrite)) |-> (idleSince == GAP_MAX_C));

  // R3: an accepted write never finds the counter at the limit.
  assert_accept_room_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrReady) |-> (wrOccupancy != CNT_W'(DEPTH)));

endmodule

// File: tb/test_rw_turn_arbiter.sv
`timescale 1ns/1ps
module test_rw_turn_arbiter;

  localparam int DEPTH = 8;
  localparam int HIGH  = 6;
  localparam int LOW   = 2;
  localparam int TURN  = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdValid = 1'b0;
  logic          wrValid = 1'b0;
  logic          rdReady, wrReady, grantValid, grantWrite;
  logic [CW-1:0] wrOccupancy;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // Reference state, derived from the requirements.
  int mOcc, mTurn, mDrain, mDir, mExited;
  int eGrant, eWrite, eRdy, eWrRdy;
  // Independent gap tracking (R8).
  int lastDirTb, idleTb, seenTb;
  bit sawFull = 1'b0;

  always #2 clk = ~clk;

  rw_turn_arbiter #(
    .DEPTH(DEPTH), .HIGH_MARK(HIGH), .LOW_MARK(LOW), .TURN_CYCLES(TURN)
  ) i_rw_turn_arbiter (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdReady(rdReady),
    .wrValid(wrValid), .wrReady(wrReady), .wrOccupancy(wrOccupancy),
    .grantValid(grantValid), .grantWrite(grantWrite)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    mOcc = 0; mTurn = 0; mDrain = 0; mDir = 0; mExited = 0;
    lastDirTb = 0; idleTb = 0; seenTb = 0;
  endfunction

  // Expected outputs for the current inputs.
  function automatic void modelEval(input int rv);
    int wantV, wantD;
    wantV = 0; wantD = 0;
    if (mDrain != 0) begin wantV = (mOcc > 0); wantD = 1; end
    else if (rv != 0) begin wantV = 1; wantD = 0; end
    else if (mOcc > 0) begin wantV = 1; wantD = 1; end
    eGrant = (wantV != 0 && mTurn == 0 && wantD == mDir);
    eWrite = eGrant && mDir == 1;
    eRdy   = eGrant && mDir == 0;
    eWrRdy = (mOcc < DEPTH);
    if (wantV != 0 && mTurn == 0 && wantD != mDir) begin
      mTurn = -1; // marks a turnaround starting this cycle
      mDir  = wantD;
    end
  endfunction

  function automatic void modelStep(input int wv);
    int prevDrain;
    if (wv != 0 && eWrRdy != 0) mOcc++;
    if (eWrite != 0) mOcc--;
    prevDrain = mDrain;
    if (mDrain != 0) mDrain = (mOcc > LOW);
    else mDrain = (mOcc >= HIGH);
    mExited = (prevDrain != 0 && mDrain == 0);
    if (mTurn == -1) mTurn = TURN - 1;
    else if (mTurn > 0) mTurn--;
  endfunction

  // One cycle: drive at the falling edge, check just after, advance the model.
  task automatic cycle(input bit rv, input bit wv);
    string tag;
    int turnBefore, exitedBefore;
    @(negedge clk);
    rdValid = rv; wrValid = wv;
    #0.5;
    turnBefore = mTurn;
    exitedBefore = mExited;
    modelEval(rv);
    if (mDrain != 0) tag = "R6";
    else if (exitedBefore != 0) tag = "R7";
    else if (turnBefore != 0) tag = "R8";
    else if (eWrite != 0) tag = "R5";
    else tag = "R4";
    check({tag, " grantValid"}, grantValid, eGrant);
    check({tag, " grantWrite"}, grantWrite, eWrite);
    check("R9 rdReady", rdReady, eRdy);
    check("R3 wrReady", wrReady, eWrRdy);
    check("R2 occupancy", wrOccupancy, mOcc);
    if (!wrReady) sawFull = 1'b1;
    if (grantValid) begin
      if (seenTb != 0 && grantWrite != lastDirTb)
        check("R8 idle gap", (idleTb >= TURN), 1);
      lastDirTb = grantWrite; idleTb = 0; seenTb = 1;
    end else begin
      idleTb++;
    end
    modelStep(wv);
  endtask

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1: reset state.
    check("R1 occupancy", wrOccupancy, 0);
    check("R1 grantValid", grantValid, 0);
    check("R1 wrReady", wrReady, 1);
    // R1: a read in the first cycle is granted at once (bus faces reads).
    rdValid = 1'b1;
    #0.5;
    check("R1 first read", rdReady, 1);
    rdValid = 1'b0;
    modelEval(1); modelStep(0);

    // Directed: reads and writes together, so the drain fills the buffer (R3, R6).
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b1);
    check("R3 full seen", sawFull, 1);
    // Reads only: drain to the low mark, then reads resume (R7).
    for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0);
    // Opportunistic writes with no reads (R5).
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) cycle(1'b0, 1'b0);
    check("R5 drained idle", wrOccupancy, 0);

    // Random segments with changing read and write density.
    for (int s = 0; s < 30; s++) begin
      int pr, pw;
      pr = $urandom_range(0, 100);
      pw = $urandom_range(0, 100);
      for (int i = 0; i < 150; i++)
        cycle($urandom_range(0, 99) < pr, $urandom_range(0, 99) < pw);
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule